// File: doc/BRIEF.md
# Strap-configured host bus slave

This block connects an external microprocessor bus to a small internal register file and a byte-wide stream buffer. Three configuration pins are captured while reset is held. They fix the data path width (8 or 16 bits), the byte lane order in 16-bit mode and the handshake style. The handshake is either a direction line qualified by a data strobe, or separate read and write strobes. A 4-bit address picks the register being accessed. The host signals are sampled on the block clock.

The host pushes stream bytes through a data port register. A ready flag tells the host when it may send a burst of up to a programmable number of bytes without polling. An interrupt line reports masked, sticky event flags. The acknowledge/wait pin and the interrupt pin are modelled as a value plus an output enable, so that the board sees them floating when they are not asserted.

Top module: `hbus_slave`

## Requirements
- R1: The width, lane-order and protocol straps are captured on every clock while reset is low. Once reset is high, changes on the strap pins have no effect until the next reset.
- R2: Width strap low selects 8-bit mode, which uses data lanes [7:0] only. An even address reaches bits [7:0] of a register and an odd address reaches bits [15:8]. Only hd_oe_o[0] is driven on reads, and hd_o[15:8] reads 0.
- R3: Width strap high selects 16-bit mode with both lane enables driven on reads. Lane-order strap low carries register bits [15:8] on hd[15:8]. Lane-order strap high swaps the two bytes.
- R4: Protocol strap low: an access is cs_ni low with stb_rdn_i low, and dir_wrn_i high means read. ack_n_o is driven low (ack_oe_o high) from the cycle after the strobe is first sampled until one cycle after it is released. Read data is valid on hd_o while the acknowledge is driven.
- R5: Protocol strap high: stb_rdn_i low is a read strobe and dir_wrn_i low is a write strobe, both qualified by cs_ni low. The wait pin (ack_n_o low, ack_oe_o high) is driven only in the first sampled cycle of an access.
- R6: The register index is addr[3:1], and addr[0] is ignored in 16-bit mode. The map is: 0 stream data port (write) and buffer fill count (read); 1 burst length (reset value 4); 2 event status; 3 event mask; 4 to 7 general read/write registers that reset to 0.
- R7: rdy_o rises once the buffer has free space of at least one burst. It drops in the cycle after the write that completes a burst, and stays low until the free space again reaches one burst.
- R8: A burst length of 0 acts as 1, and a length above the buffer depth acts as the depth. The register reads back the value as written.
- R9: Stream bytes leave st_data_o in arrival order, and a 16-bit write enqueues register bits [7:0] first. A write that does not fit entirely is discarded. The buffer never holds more than its depth.
- R10: A pulse on irq_src_i sets the matching sticky status bit. The interrupt is asserted (irq_n_o low, irq_oe_o high) while any status bit has its mask bit at 1. It is released (irq_oe_o low) otherwise.
- R11: Reading the status register returns it and clears it. Clearing a mask bit, or reset, also removes the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| strap_wide_i | input | 1 | Width strap: 0 = 8-bit, 1 = 16-bit |
| strap_swap_i | input | 1 | Lane-order strap for 16-bit mode |
| strap_sep_i | input | 1 | Protocol strap: 0 = direction + strobe, 1 = separate strobes |
| cs_ni | input | 1 | Chip select, active low |
| dir_wrn_i | input | 1 | Direction (high = read), or write strobe active low |
| stb_rdn_i | input | 1 | Data strobe, or read strobe, active low |
| addr_i | input | 4 | Register address |
| hd_i | input | 16 | Host data in |
| hd_o | output | 16 | Host data out |
| hd_oe_o | output | 2 | Per-lane data output enable (bit 1 = upper lane) |
| ack_n_o | output | 1 | Acknowledge / wait value, active low |
| ack_oe_o | output | 1 | Acknowledge / wait output enable |
| rdy_o | output | 1 | Burst ready flag |
| irq_n_o | output | 1 | Interrupt value, active low |
| irq_oe_o | output | 1 | Interrupt output enable |
| irq_src_i | input | 8 | Event pulses, one per status bit |
| st_data_o | output | 8 | Oldest stream byte |
| st_valid_o | output | 1 | Stream buffer not empty |
| st_pop_i | input | 1 | Consume the oldest stream byte |

## Verification
The bench changes the strap pins after reset release and checks that lane mapping and width stay as captured. A design that samples the straps live would move the data onto the wrong lane. It fills the buffer with a burst length above the depth. A design without clamping would never drop ready. Without the overflow guard, the extra write would corrupt the fill count. It also uses a burst length of 0, where a design without the minimum of 1 would never end the burst. The interrupt checks cover a masked event, clearing on a status read, clearing by the mask and clearing by reset. Both handshakes are timed cycle by cycle, so an acknowledge or wait pulse that is one cycle off is reported.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
    localparam int DW = 16;
    localparam int IW = 3;

    typedef struct packed {
        logic wide;
        logic swap;
        logic sep;
    } hb_cfg_t;

    localparam logic [IW-1:0] RIX_STREAM = 3'd0;
    localparam logic [IW-1:0] RIX_BLEN   = 3'd1;
    localparam logic [IW-1:0] RIX_STAT   = 3'd2;
    localparam logic [IW-1:0] RIX_MASK   = 3'd3;
endpackage

// File: rtl/hbus_strap.sv
module hbus_strap
    import hbus_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    wide_i,
    input  logic    swap_i,
    input  logic    sep_i,
    output hb_cfg_t cfg_o
);
    hb_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_ni) begin
            cfg_d.wide = wide_i;
            cfg_d.swap = swap_i;
            cfg_d.sep  = sep_i;
        end
    end

    always_ff @(posedge clk_i) cfg_q <= cfg_d;

    assign cfg_o = cfg_q;

    AST_STRAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> $stable(cfg_q)); // R1
endmodule

// File: rtl/hbus_front.sv
module hbus_front
    import hbus_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  hb_cfg_t       cfg_i,
    input  logic          cs_ni,
    input  logic          dir_wrn_i,
    input  logic          stb_rdn_i,
    input  logic [3:0]    addr_i,
    input  logic [DW-1:0] hd_i,
    input  logic [DW-1:0] rdata_i,
    output logic [IW-1:0] idx_o,
    output logic [1:0]    be_o,
    output logic [DW-1:0] wdata_o,
    output logic          wr_o,
    output logic          rd_o,
    output logic [DW-1:0] hd_o,
    output logic [1:0]    hd_oe_o,
    output logic          ack_n_o,
    output logic          ack_oe_o
);
    typedef struct packed {
        logic          busy;
        logic          rd;
        logic [DW-1:0] rdata;
    } fe_t;

    fe_t  s_d, s_q;
    logic access, is_read, start;
    logic [DW-1:0] rlane;

    always_comb begin
        s_d = s_q;
        if (cfg_i.sep) begin
            access  = !cs_ni && (!stb_rdn_i || !dir_wrn_i);
            is_read = !stb_rdn_i;
        end else begin
            access  = !cs_ni && !stb_rdn_i;
            is_read = dir_wrn_i;
        end
        start = access && !s_q.busy;

        if (cfg_i.wide) begin
            wdata_o = cfg_i.swap ? {hd_i[7:0], hd_i[15:8]} : hd_i;
            be_o    = 2'b11;
            rlane   = cfg_i.swap ? {rdata_i[7:0], rdata_i[15:8]} : rdata_i;
        end else begin
            wdata_o = {hd_i[7:0], hd_i[7:0]};
            be_o    = addr_i[0] ? 2'b10 : 2'b01;
            rlane   = {8'h00, addr_i[0] ? rdata_i[15:8] : rdata_i[7:0]};
        end

        s_d.busy = access;
        if (start) begin
            s_d.rd    = is_read;
            s_d.rdata = rlane;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign idx_o    = addr_i[3:1];
    assign wr_o     = start && !is_read;
    assign rd_o     = start && is_read;
    assign hd_o     = s_q.rdata;
    assign hd_oe_o  = {cfg_i.wide, 1'b1} & {2{s_q.busy && s_q.rd}};
    assign ack_oe_o = cfg_i.sep ? start : s_q.busy;
    assign ack_n_o  = !ack_oe_o;

    AST_ACK_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_i.sep && $past(wr_o || rd_o)) |-> (ack_oe_o && !ack_n_o)); // R4
    AST_WAIT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_i.sep && $past(wr_o || rd_o)) |-> !ack_oe_o); // R5
endmodule

// File: rtl/hbus_regs.sv
module hbus_regs
    import hbus_pkg::*;
#(
    parameter int IRQ_W    = 8,
    parameter int BLEN_RST = 4,
    parameter int CW       = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IW-1:0]    idx_i,
    input  logic [1:0]       be_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [IRQ_W-1:0] irq_src_i,
    input  logic [CW-1:0]    fill_i,
    output logic [DW-1:0]    rdata_o,
    output logic [1:0]       push_n_o,
    output logic [7:0]       push_b0_o,
    output logic [7:0]       push_b1_o,
    output logic [DW-1:0]    blen_o,
    output logic             irq_n_o,
    output logic             irq_oe_o
);
    typedef struct packed {
        logic [DW-1:0]         blen;
        logic [IRQ_W-1:0]      stat;
        logic [IRQ_W-1:0]      mask;
        logic [3:0][DW-1:0]    scr;
    } rf_t;

    rf_t  s_d, s_q;
    logic irq_act;

    function automatic logic [DW-1:0] bwr(input logic [DW-1:0] o, input logic [DW-1:0] w,
                                          input logic [1:0] be);
        bwr = {be[1] ? w[15:8] : o[15:8], be[0] ? w[7:0] : o[7:0]};
    endfunction

    always_comb begin
        s_d = s_q;
        case (idx_i)
            RIX_STREAM: rdata_o = DW'(fill_i);
            RIX_BLEN:   rdata_o = s_q.blen;
            RIX_STAT:   rdata_o = DW'(s_q.stat);
            RIX_MASK:   rdata_o = DW'(s_q.mask);
            default:    rdata_o = s_q.scr[idx_i[1:0]];
        endcase

        push_n_o  = 2'd0;
        push_b0_o = be_i[0] ? wdata_i[7:0] : wdata_i[15:8];
        push_b1_o = wdata_i[15:8];
        if (wr_i) begin
            case (idx_i)
                RIX_STREAM: push_n_o = (be_i == 2'b11) ? 2'd2 : 2'd1;
                RIX_BLEN:   s_d.blen = bwr(s_q.blen, wdata_i, be_i);
                RIX_STAT:   ;
                RIX_MASK:   s_d.mask = IRQ_W'(bwr(DW'(s_q.mask), wdata_i, be_i));
                default:    s_d.scr[idx_i[1:0]] = bwr(s_q.scr[idx_i[1:0]], wdata_i, be_i);
            endcase
        end
        if (rd_i && idx_i == RIX_STAT) s_d.stat = '0;
        s_d.stat = s_d.stat | irq_src_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q      <= '0;
            s_q.blen <= DW'(BLEN_RST);
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_act  = |(s_q.stat & s_q.mask);
    assign irq_n_o  = !irq_act;
    assign irq_oe_o = irq_act;
    assign blen_o   = s_q.blen;

    AST_STAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rd_i && idx_i == RIX_STAT && irq_src_i == '0) |-> (s_q.stat == '0)); // R11
    AST_SRC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(irq_src_i != '0) |-> ((s_q.stat & $past(irq_src_i)) == $past(irq_src_i))); // R10
endmodule

// File: rtl/hbus_stream.sv
module hbus_stream
    import hbus_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [1:0]    push_n_i,
    input  logic [7:0]    b0_i,
    input  logic [7:0]    b1_i,
    input  logic [DW-1:0] blen_i,
    input  logic          pop_i,
    output logic [7:0]    data_o,
    output logic          valid_o,
    output logic [CW-1:0] fill_o,
    output logic          rdy_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int EW = CW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [CW-1:0]         cnt;
        logic [CW-1:0]         cb;
        logic                  rdy;
    } sb_t;

    sb_t  s_d, s_q;
    logic [EW-1:0] eff, room, fit_sum, b_sum;
    logic pop_ok, acc, room_ok;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        nxt = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (blen_i == '0)               eff = EW'(1);
        else if (blen_i > DW'(DEPTH))   eff = EW'(DEPTH);
        else                            eff = EW'(blen_i);
        room    = EW'(DEPTH) - EW'(s_q.cnt);
        room_ok = room >= eff;
        fit_sum = EW'(s_q.cnt) + EW'(push_n_i);
        b_sum   = EW'(s_q.cb) + EW'(push_n_i);
        pop_ok  = pop_i && (s_q.cnt != '0);
        acc     = (push_n_i != 2'd0) && (fit_sum <= EW'(DEPTH));

        if (pop_ok) s_d.rp = nxt(s_q.rp);
        if (acc) begin
            s_d.mem[s_q.wp] = b0_i;
            if (push_n_i == 2'd2) begin
                s_d.mem[nxt(s_q.wp)] = b1_i;
                s_d.wp = nxt(nxt(s_q.wp));
            end else begin
                s_d.wp = nxt(s_q.wp);
            end
        end
        s_d.cnt = s_q.cnt + (acc ? CW'(push_n_i) : '0) - (pop_ok ? CW'(1) : '0);

        if (s_q.rdy) begin
            if (acc) begin
                if (b_sum >= eff) begin
                    s_d.rdy = 1'b0;
                    s_d.cb  = '0;
                end else begin
                    s_d.cb  = CW'(b_sum);
                end
            end
        end else if (room_ok) begin
            s_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign data_o  = s_q.mem[s_q.rp];
    assign valid_o = s_q.cnt != '0;
    assign fill_o  = s_q.cnt;
    assign rdy_o   = s_q.rdy;

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= CW'(DEPTH)); // R9
    AST_RDY_NEEDS_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.rdy) |-> $past(room_ok)); // R7
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int IRQ_W    = 8,
    parameter int BLEN_RST = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             strap_wide_i,
    input  logic             strap_swap_i,
    input  logic             strap_sep_i,
    input  logic             cs_ni,
    input  logic             dir_wrn_i,
    input  logic             stb_rdn_i,
    input  logic [3:0]       addr_i,
    input  logic [15:0]      hd_i,
    output logic [15:0]      hd_o,
    output logic [1:0]       hd_oe_o,
    output logic             ack_n_o,
    output logic             ack_oe_o,
    output logic             rdy_o,
    output logic             irq_n_o,
    output logic             irq_oe_o,
    input  logic [IRQ_W-1:0] irq_src_i,
    output logic [7:0]       st_data_o,
    output logic             st_valid_o,
    input  logic             st_pop_i
);
    localparam int CW = $clog2(DEPTH + 1);

    hb_cfg_t       cfg;
    logic [IW-1:0] idx;
    logic [1:0]    be, push_n;
    logic [DW-1:0] wdata, rdata, blen;
    logic          wr, rd;
    logic [7:0]    b0, b1;
    logic [CW-1:0] fill;

    hbus_strap u_strap (
        .clk_i(clk_i), .rst_ni(rst_ni), .wide_i(strap_wide_i),
        .swap_i(strap_swap_i), .sep_i(strap_sep_i), .cfg_o(cfg)
    );

    hbus_front u_front (
        .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg), .cs_ni(cs_ni),
        .dir_wrn_i(dir_wrn_i), .stb_rdn_i(stb_rdn_i), .addr_i(addr_i),
        .hd_i(hd_i), .rdata_i(rdata), .idx_o(idx), .be_o(be),
        .wdata_o(wdata), .wr_o(wr), .rd_o(rd), .hd_o(hd_o),
        .hd_oe_o(hd_oe_o), .ack_n_o(ack_n_o), .ack_oe_o(ack_oe_o)
    );

    hbus_regs #(.IRQ_W(IRQ_W), .BLEN_RST(BLEN_RST), .CW(CW)) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(idx), .be_i(be),
        .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .irq_src_i(irq_src_i),
        .fill_i(fill), .rdata_o(rdata), .push_n_o(push_n),
        .push_b0_o(b0), .push_b1_o(b1), .blen_o(blen),
        .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o)
    );

    hbus_stream #(.DEPTH(DEPTH), .CW(CW)) u_stream (
        .clk_i(clk_i), .rst_ni(rst_ni), .push_n_i(push_n), .b0_i(b0),
        .b1_i(b1), .blen_i(blen), .pop_i(st_pop_i), .data_o(st_data_o),
        .valid_o(st_valid_o), .fill_o(fill), .rdy_o(rdy_o)
    );
endmodule

// File: tb/hbus_slave_tb_top.sv
module hbus_slave_tb_top;
    localparam time TCK = 8ns;

    typedef struct packed {
        logic        wr;
        logic [3:0]  a;
        logic [15:0] d;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'h8, 16'h0000, 16'h0000},
        '{1'b1, 4'h8, 16'hA5C3, 16'h0000},
        '{1'b0, 4'h9, 16'h0000, 16'hA5C3},
        '{1'b1, 4'hA, 16'h1234, 16'h0000},
        '{1'b0, 4'hA, 16'h0000, 16'h1234},
        '{1'b0, 4'h8, 16'h0000, 16'hA5C3},
        '{1'b0, 4'h2, 16'h0000, 16'h0004},
        '{1'b1, 4'hE, 16'hFFFF, 16'h0000},
        '{1'b0, 4'hF, 16'h0000, 16'hFFFF},
        '{1'b0, 4'h0, 16'h0000, 16'h0000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic s_wide = 1'b1, s_swap = 1'b0, s_sep = 1'b0;
    logic cs_n = 1'b1, dir_wrn = 1'b1, stb_rdn = 1'b1;
    logic [3:0] addr = '0;
    logic [15:0] hd_in = '0, hd_out;
    logic [1:0] hd_oe;
    logic ack_n, ack_oe, rdy, irq_n, irq_oe, st_valid, st_pop = 1'b0;
    logic [7:0] irq_src = '0, st_data;

    int n_chk = 0, n_bad = 0;
    bit done = 0, proto_b = 0;
    logic [15:0] rq;
    logic pre_oe, pre_n, mid_oe, mid_n, end_oe, rdy_mid;
    logic [1:0] hdoe_mid;

    always #(TCK/2) clk = ~clk;

    hbus_slave dut_i (
        .clk_i(clk), .rst_ni(rst_n), .strap_wide_i(s_wide), .strap_swap_i(s_swap),
        .strap_sep_i(s_sep), .cs_ni(cs_n), .dir_wrn_i(dir_wrn), .stb_rdn_i(stb_rdn),
        .addr_i(addr), .hd_i(hd_in), .hd_o(hd_out), .hd_oe_o(hd_oe),
        .ack_n_o(ack_n), .ack_oe_o(ack_oe), .rdy_o(rdy), .irq_n_o(irq_n),
        .irq_oe_o(irq_oe), .irq_src_i(irq_src), .st_data_o(st_data),
        .st_valid_o(st_valid), .st_pop_i(st_pop)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic w, input logic sw, input logic sp);
        @(negedge clk);
        rst_n = 1'b0; s_wide = w; s_swap = sw; s_sep = sp; proto_b = sp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic acc(input logic wr, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        cs_n = 1'b0; addr = a; hd_in = d;
        if (proto_b) begin
            if (wr) dir_wrn = 1'b0; else stb_rdn = 1'b0;
        end else begin
            dir_wrn = !wr; stb_rdn = 1'b0;
        end
        #1;
        pre_oe = ack_oe; pre_n = ack_n;
        @(negedge clk);
        rq = hd_out; mid_oe = ack_oe; mid_n = ack_n; rdy_mid = rdy; hdoe_mid = hd_oe;
        cs_n = 1'b1; dir_wrn = 1'b1; stb_rdn = 1'b1;
        @(negedge clk);
        end_oe = ack_oe;
    endtask

    task automatic pop_chk(input string tag, input logic [7:0] exp);
        @(negedge clk);
        chk(tag, {st_valid, st_data}, {1'b1, exp});
        st_pop = 1'b1;
        @(negedge clk);
        st_pop = 1'b0;
    endtask

    task automatic pulse_src(input logic [7:0] v);
        @(negedge clk); irq_src = v;
        @(negedge clk); irq_src = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: all requirements, actual=hang expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1, 1'b0, 1'b0);
        // reset state
        chk("R4 reset ack_oe", ack_oe, 0);
        chk("R2 reset hd_oe", hd_oe, 0);
        chk("R10 reset irq_oe", irq_oe, 0);
        chk("R9 reset st_valid", st_valid, 0);
        repeat (2) @(negedge clk);
        chk("R7 ready after reset", rdy, 1);

        // vector table: 16-bit, natural lanes, direction+strobe
        for (int i = 0; i < NV; i++) begin
            acc(VEC[i].wr, VEC[i].a, VEC[i].d);
            chk("R4 ack timing", {pre_oe, mid_oe, mid_n, end_oe}, 4'b0100);
            if (!VEC[i].wr) begin
                chk("R6 read data", rq, VEC[i].exp);
                chk("R3 read lanes", hdoe_mid, 2'b11);
            end
        end

        // burst of default length 4
        acc(1, 4'h0, 16'hBBAA);
        chk("R7 ready mid burst", rdy_mid, 1);
        acc(1, 4'h0, 16'hDDCC);
        chk("R7 ready drops at burst end", rdy_mid, 0);
        repeat (2) @(negedge clk);
        chk("R7 ready back with room", rdy, 1);
        acc(0, 4'h0, 16'h0);
        chk("R9 fill count", rq, 16'd4);
        pop_chk("R9 order b0", 8'hAA);
        pop_chk("R9 order b1", 8'hBB);
        pop_chk("R9 order b2", 8'hCC);
        pop_chk("R9 order b3", 8'hDD);

        // burst length above depth, fill buffer, overflow write
        acc(1, 4'h2, 16'h0020);
        for (int k = 0; k < 8; k++) begin
            acc(1, 4'h0, {8'(2*k+1), 8'(2*k)});
            if (k == 6) chk("R8 ready before clamped end", rdy_mid, 1);
        end
        chk("R8 clamped burst ends at depth", rdy_mid, 0);
        acc(1, 4'h0, 16'hEEEE);
        repeat (3) @(negedge clk);
        chk("R7 ready low while full", rdy, 0);
        acc(0, 4'h0, 16'h0);
        chk("R9 overflow write discarded", rq, 16'd16);
        acc(0, 4'h2, 16'h0);
        chk("R8 burst length reads raw", rq, 16'h0020);
        for (int k = 0; k < 16; k++) pop_chk("R9 full drain order", 8'(k));
        repeat (3) @(negedge clk);
        chk("R7 ready after drain", rdy, 1);

        // burst length zero acts as one
        acc(1, 4'h2, 16'h0000);
        acc(1, 4'h0, 16'h2211);
        chk("R8 zero length ends burst", rdy_mid, 0);
        pop_chk("R9 zero-len b0", 8'h11);
        pop_chk("R9 zero-len b1", 8'h22);

        // interrupts
        pulse_src(8'h04);
        chk("R10 masked event quiet", irq_oe, 0);
        acc(1, 4'h6, 16'h0004);
        chk("R10 unmasked event asserts", {irq_oe, irq_n}, 2'b10);
        acc(0, 4'h4, 16'h0);
        chk("R11 status read value", rq, 16'h0004);
        chk("R11 status read clears", irq_oe, 0);
        pulse_src(8'h04);
        chk("R10 event again", {irq_oe, irq_n}, 2'b10);
        acc(1, 4'h6, 16'h0000);
        chk("R11 mask clears", irq_oe, 0);
        acc(1, 4'h6, 16'h0004);
        chk("R10 status still sticky", irq_oe, 1);
        do_reset(1'b1, 1'b1, 1'b0);
        chk("R11 reset clears irq", irq_oe, 0);

        // swapped lanes in 16-bit mode, strap change after reset
        acc(1, 4'h0, 16'h3412);
        acc(0, 4'h0, 16'h0);
        chk("R3 swapped fill read", rq, 16'h0200);
        @(negedge clk); s_swap = 1'b0;
        acc(0, 4'h0, 16'h0);
        chk("R1 swap strap ignored", rq, 16'h0200);
        pop_chk("R3 swapped byte order b0", 8'h34);
        pop_chk("R3 swapped byte order b1", 8'h12);

        // 8-bit mode, separate strobes
        do_reset(1'b0, 1'b0, 1'b1);
        acc(1, 4'h8, 16'hFF5A);
        chk("R5 write wait timing", {pre_oe, pre_n, mid_oe, end_oe}, 4'b1000);
        acc(1, 4'h9, 16'h00C3);
        acc(0, 4'h9, 16'h0);
        chk("R5 read wait timing", {pre_oe, pre_n, mid_oe, end_oe}, 4'b1000);
        chk("R2 odd address high byte", rq, 16'h00C3);
        chk("R2 low lane only", hdoe_mid, 2'b01);
        acc(0, 4'h8, 16'h0);
        chk("R2 even address low byte", rq, 16'h005A);
        @(negedge clk); s_wide = 1'b1; s_sep = 1'b0;
        acc(0, 4'h9, 16'h0);
        chk("R1 width strap ignored", {hdoe_mid, rq}, {2'b01, 16'h00C3});
        acc(1, 4'h1, 16'h0077);
        pop_chk("R2 byte stream push", 8'h77);
        acc(0, 4'h0, 16'h0);
        chk("R9 fill after pop", rq, 16'h0000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule